// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-side register set of a four-channel DMA controller. Software reaches it through an 8-bit I/O port bus with sixteen port offsets. Each channel has a 16-bit start address and a 16-bit transfer count. Both travel through one byte-wide port per value. A byte-order flip-flop, shared by all channels, steers the first access to the low byte and the second to the high byte. Software returns this flip-flop to the low-byte state with a dedicated command port.

Besides the per-channel values, the block holds the following state:
- a mode register for each channel;
- a mask bit for each channel;
- a command register;
- a software request register.

It also carries out three commands: master clear, clear all masks and load all masks. The transfer logic sees masks, modes, commands, requests and both the base and the current copies of each address and count. It writes the current copies back through an update port as the transfer moves on.

Top module: `dma_prog_regs`

## Requirements
- R1: After reset, every channel mask is 1, the command register and software requests are 0, and all addresses and counts are 0. A read of offset 8 (status) returns 0x00.
- R2: Offset 2n is the address port of channel n and offset 2n+1 is its count port. The first access after a pointer clear carries bits 7:0 and the second carries bits 15:8.
- R3: A write of any value to offset 12 returns the byte pointer to the low-byte state.
- R4: A read of a count or address port returns the current copy of that value through the same byte pointer. A count is stored as transfers minus one, so 0xFFFF reads back unchanged.
- R5: The byte pointer toggles on every read or write of offsets 0 to 7, and it is shared across all channels.
- R6: A write to offset 10 selects the channel with bits 1:0. Bit 2 = 1 sets that channel's mask and bit 2 = 0 clears it. The other masks keep their values.
- R7: A write to offset 14 clears all four masks. A write to offset 15 loads the masks from bits 3:0, with bit n going to channel n.
- R8: A write to offset 11 selects the channel with bits 1:0 and stores bits 7:2 in that channel's 6-bit mode field, with bit 2 landing in field bit 0. For example, 0x44 gives 0x11, 0x48 gives 0x12 and 0xC0 gives 0x30.
- R9: A write to offset 8 loads the command register. A write to offset 9 selects the channel with bits 1:0 and sets (bit 2 = 1) or clears that channel's software request. A read of offset 8 returns the requests in bits 7:4 and zeros in bits 3:0.
- R10: A write to offset 13 clears the command register and all requests, sets all masks and returns the byte pointer to low. Addresses and counts keep their values.
- R11: An address or count write from the host loads both the base and the current copy. An update pulse on a channel loads only the current copies, and a host write on the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe, one access per cycle |
| rdata_o | output | 8 | Read data, valid in the cycle of rd_i |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel masks, 1 = disabled |
| sw_req_o | output | 4 | Software requests |
| mode_o | output | 24 | Mode fields, 6 bits per channel, channel 0 in the lowest bits |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| cur_addr_o | output | 64 | Current addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |
| cur_cnt_o | output | 64 | Current counts, 16 bits per channel |
| upd_en_i | input | 4 | Per-channel current-copy update strobe |
| upd_addr_i | input | 16 | Current address to load on update |
| upd_cnt_i | input | 16 | Current count to load on update |

## Verification
Every write and update reaches the register outputs at the first rising edge after the strobe. Read data is combinational and valid within the cycle of rd_i, and the byte pointer advances at that same edge. The bench drives each access on a falling edge. It samples read data one time step later, before the capturing edge. It samples register outputs at the next falling edge, after exactly one capturing edge. Pointer sharing is checked by interleaving accesses to different channels and observing which byte each one lands on or returns.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 4;
  localparam int unsigned REG_W  = 2 * DW;
  localparam int unsigned MODE_W = DW - CH_W;
  localparam int unsigned REQ_LSB = DW - NUM_CH;

  localparam logic [AW-1:0] P_CMD     = 4'd8;
  localparam logic [AW-1:0] P_REQ     = 4'd9;
  localparam logic [AW-1:0] P_MASK1   = 4'd10;
  localparam logic [AW-1:0] P_MODE    = 4'd11;
  localparam logic [AW-1:0] P_CLRPTR  = 4'd12;
  localparam logic [AW-1:0] P_MCLR    = 4'd13;
  localparam logic [AW-1:0] P_CLRMASK = 4'd14;
  localparam logic [AW-1:0] P_MASKALL = 4'd15;

  // bit in a single-channel write that sets (1) or clears (0)
  localparam int unsigned SET_BIT = 2;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_o <= 1'b0;
    else if (clr_i)   hi_o <= 1'b0;
    else if (step_i)  hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_i,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              mode_wr_i,
  input  logic              upd_i,
  input  logic [REG_W-1:0]  upd_addr_i,
  input  logic [REG_W-1:0]  upd_cnt_i,
  output logic [REG_W-1:0]  base_addr_o,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  base_cnt_o,
  output logic [REG_W-1:0]  cur_cnt_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [REG_W-1:0] addr_new, cnt_new;

  // byte merge of host data into the base copy
  always_comb begin
    addr_new = base_addr_o;
    cnt_new  = base_cnt_o;
    if (hi_i) begin
      addr_new[REG_W-1:DW] = wdata_i;
      cnt_new[REG_W-1:DW]  = wdata_i;
    end else begin
      addr_new[DW-1:0] = wdata_i;
      cnt_new[DW-1:0]  = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_o <= '0;
      cur_addr_o  <= '0;
      base_cnt_o  <= '0;
      cur_cnt_o   <= '0;
    end else begin
      if (wr_addr_i) begin
        base_addr_o <= addr_new;
        cur_addr_o  <= addr_new;
      end else if (upd_i) begin
        cur_addr_o  <= upd_addr_i;
      end
      if (wr_cnt_i) begin
        base_cnt_o <= cnt_new;
        cur_cnt_o  <= cnt_new;
      end else if (upd_i) begin
        cur_cnt_o  <= upd_cnt_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_o <= '0;
    else if (mode_wr_i) mode_o <= wdata_i[DW-1:CH_W];
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     wdata_i,
  input  logic              cmd_wr_i,
  input  logic              req_wr_i,
  input  logic              mask1_wr_i,
  input  logic              mclr_i,
  input  logic              clrmask_i,
  input  logic              maskall_i,
  output logic [DW-1:0]     cmd_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] req_o
);
  logic [CH_W-1:0] ch_sel;
  logic            set_bit;
  assign ch_sel  = wdata_i[CH_W-1:0];
  assign set_bit = wdata_i[SET_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_o <= '0;
    else if (mclr_i)   cmd_o <= '0;
    else if (cmd_wr_i) cmd_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mask_o <= '1;
    else if (mclr_i)             mask_o <= '1;
    else if (clrmask_i)          mask_o <= '0;
    else if (maskall_i)          mask_o <= wdata_i[NUM_CH-1:0];
    else if (mask1_wr_i)         mask_o[ch_sel] <= set_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_o <= '0;
    else if (mclr_i)   req_o <= '0;
    else if (req_wr_i) req_o[ch_sel] <= set_bit;
  end
endmodule

// File: rtl/dma_prog_regs.sv
module dma_prog_regs
  import dma_prog_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  output logic [DW-1:0]            rdata_o,
  output logic [DW-1:0]            cmd_o,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [NUM_CH-1:0]        sw_req_o,
  output logic [NUM_CH*MODE_W-1:0] mode_o,
  output logic [NUM_CH*REG_W-1:0]  base_addr_o,
  output logic [NUM_CH*REG_W-1:0]  cur_addr_o,
  output logic [NUM_CH*REG_W-1:0]  base_cnt_o,
  output logic [NUM_CH*REG_W-1:0]  cur_cnt_o,
  input  logic [NUM_CH-1:0]        upd_en_i,
  input  logic [REG_W-1:0]         upd_addr_i,
  input  logic [REG_W-1:0]         upd_cnt_i
);
  logic            chan_port;
  logic [CH_W-1:0] port_ch;
  logic            port_is_cnt;
  logic            byte_hi;
  logic            mclr;

  assign chan_port   = ~addr_i[AW-1];
  assign port_ch     = addr_i[CH_W:1];
  assign port_is_cnt = addr_i[0];
  assign mclr        = wr_i && (addr_i == P_MCLR);

  dma_byte_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mclr || (wr_i && (addr_i == P_CLRPTR))),
    .step_i ((wr_i || rd_i) && chan_port),
    .hi_o   (byte_hi)
  );

  dma_ctrl_regs u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_i    (wdata_i),
    .cmd_wr_i   (wr_i && (addr_i == P_CMD)),
    .req_wr_i   (wr_i && (addr_i == P_REQ)),
    .mask1_wr_i (wr_i && (addr_i == P_MASK1)),
    .mclr_i     (mclr),
    .clrmask_i  (wr_i && (addr_i == P_CLRMASK)),
    .maskall_i  (wr_i && (addr_i == P_MASKALL)),
    .cmd_o      (cmd_o),
    .mask_o     (mask_o),
    .req_o      (sw_req_o)
  );

  logic [REG_W-1:0] cur_addr_a [NUM_CH];
  logic [REG_W-1:0] cur_cnt_a  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = wr_i && chan_port && (port_ch == CH_W'(c));
    dma_chan_regs u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hi_i        (byte_hi),
      .wr_addr_i   (sel && !port_is_cnt),
      .wr_cnt_i    (sel && port_is_cnt),
      .wdata_i     (wdata_i),
      .mode_wr_i   (wr_i && (addr_i == P_MODE) && (wdata_i[CH_W-1:0] == CH_W'(c))),
      .upd_i       (upd_en_i[c]),
      .upd_addr_i  (upd_addr_i),
      .upd_cnt_i   (upd_cnt_i),
      .base_addr_o (base_addr_o[c*REG_W +: REG_W]),
      .cur_addr_o  (cur_addr_o[c*REG_W +: REG_W]),
      .base_cnt_o  (base_cnt_o[c*REG_W +: REG_W]),
      .cur_cnt_o   (cur_cnt_o[c*REG_W +: REG_W]),
      .mode_o      (mode_o[c*MODE_W +: MODE_W])
    );
    assign cur_addr_a[c] = cur_addr_o[c*REG_W +: REG_W];
    assign cur_cnt_a[c]  = cur_cnt_o[c*REG_W +: REG_W];
  end

  logic [REG_W-1:0] rd_word;
  always_comb begin
    rd_word = port_is_cnt ? cur_cnt_a[port_ch] : cur_addr_a[port_ch];
    if (chan_port)
      rdata_o = byte_hi ? rd_word[REG_W-1:DW] : rd_word[DW-1:0];
    else if (addr_i == P_CMD)
      rdata_o = {sw_req_o, {REQ_LSB{1'b0}}};
    else
      rdata_o = '0;
  end
endmodule

// File: rtl/dma_prog_regs_chk.sv
module dma_prog_regs_chk
  import dma_prog_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [AW-1:0]            addr_i,
  input logic [DW-1:0]            wdata_i,
  input logic                     wr_i,
  input logic                     rd_i,
  input logic                     byte_hi_i,
  input logic [DW-1:0]            cmd_o,
  input logic [NUM_CH-1:0]        mask_o,
  input logic [NUM_CH*MODE_W-1:0] mode_o,
  input logic [NUM_CH*REG_W-1:0]  cur_cnt_o
);
  // R5
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && !addr_i[AW-1]) |=> (byte_hi_i != $past(byte_hi_i)));

  // R3
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == P_CLRPTR) |=> !byte_hi_i);

  // R10
  master_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == P_MCLR) |=> (mask_o == '1 && cmd_o == '0 && !byte_hi_i));

  // R7
  clear_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == P_CLRMASK) |=> (mask_o == '0));

  // R6
  single_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == P_MASK1) |=>
      (mask_o[$past(wdata_i[CH_W-1:0])] == $past(wdata_i[SET_BIT])));

  // R8
  mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == P_MODE) |=>
      (mode_o[$past(wdata_i[CH_W-1:0]) * MODE_W +: MODE_W] == $past(wdata_i[DW-1:CH_W])));

  // R2
  cnt_low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd1 && !byte_hi_i) |=> (cur_cnt_o[DW-1:0] == $past(wdata_i)));

  // R9
  cmd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == P_CMD) |=> (cmd_o == $past(wdata_i)));
endmodule

bind dma_prog_regs dma_prog_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .byte_hi_i (byte_hi),
  .cmd_o     (cmd_o),
  .mask_o    (mask_o),
  .mode_o    (mode_o),
  .cur_cnt_o (cur_cnt_o)
);

// File: tb/dma_prog_regs_bench.sv
module dma_prog_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, cmd;
  logic [3:0]  mask, sw_req, upd_en = '0;
  logic [23:0] mode;
  logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;
  logic [15:0] upd_addr = '0, upd_cnt = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_prog_regs u_dma_prog_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .cmd_o(cmd), .mask_o(mask),
    .sw_req_o(sw_req), .mode_o(mode), .base_addr_o(base_addr),
    .cur_addr_o(cur_addr), .base_cnt_o(base_cnt), .cur_cnt_o(cur_cnt),
    .upd_en_i(upd_en), .upd_addr_i(upd_addr), .upd_cnt_i(upd_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_port(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_port(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(mask == 4'hF, "R1 masks", 32'(mask), 32'hF);
    chk(cmd == 8'h00 && sw_req == 4'h0, "R1 cmd/req", {cmd, 4'h0, sw_req}, 0);
    chk(cur_cnt == 64'h0 && base_addr == 64'h0, "R1 regs", cur_cnt[31:0], 0);
    rd_port(4'd8, d);
    chk(d == 8'h00, "R1 status", 32'(d), 0);
  endtask

  task automatic t_addr_load;
    wr_port(4'd12, 8'h00);
    wr_port(4'd2, 8'h34);
    wr_port(4'd2, 8'h12);
    chk(base_addr[31:16] == 16'h1234, "R2 ch1 base addr", 32'(base_addr[31:16]), 32'h1234);
    chk(cur_addr[31:16] == 16'h1234, "R11 ch1 cur addr", 32'(cur_addr[31:16]), 32'h1234);
  endtask

  task automatic t_count_rw;
    logic [7:0] lo, hi;
    wr_port(4'd12, 8'hA5);
    wr_port(4'd7, 8'hFF);
    wr_port(4'd7, 8'hFF);
    chk(base_cnt[63:48] == 16'hFFFF, "R2 ch3 count", 32'(base_cnt[63:48]), 32'hFFFF);
    rd_port(4'd7, lo);
    rd_port(4'd7, hi);
    chk({hi, lo} == 16'hFFFF, "R4 ch3 readback", 32'({hi, lo}), 32'hFFFF);
  endtask

  task automatic t_shared_ptr;
    logic [7:0] d;
    wr_port(4'd12, 8'h00);
    wr_port(4'd5, 8'h3C);
    wr_port(4'd5, 8'h5A);
    wr_port(4'd0, 8'hAA);   // low byte, pointer now high
    rd_port(4'd5, d);       // high byte of ch2 count, pointer now low
    chk(d == 8'h5A, "R5 read after other-channel write", 32'(d), 32'h5A);
    wr_port(4'd0, 8'hBB);
    chk(base_addr[15:0] == 16'h00BB, "R5 ch0 addr low", 32'(base_addr[15:0]), 32'h00BB);
  endtask

  task automatic t_ptr_clear;
    wr_port(4'd12, 8'h00);
    wr_port(4'd1, 8'h77);   // pointer high
    wr_port(4'd12, 8'hFF);
    wr_port(4'd1, 8'h11);
    chk(base_cnt[15:0] == 16'h0011, "R3 clear mid-pair", 32'(base_cnt[15:0]), 32'h0011);
  endtask

  task automatic t_single_mask;
    wr_port(4'd10, 8'h01);
    chk(mask == 4'hD, "R6 unmask ch1", 32'(mask), 32'hD);
    wr_port(4'd10, 8'h03);
    chk(mask == 4'h5, "R6 unmask ch3", 32'(mask), 32'h5);
    wr_port(4'd10, 8'h05);
    chk(mask == 4'h7, "R6 mask ch1", 32'(mask), 32'h7);
  endtask

  task automatic t_group_mask;
    wr_port(4'd14, 8'h00);
    chk(mask == 4'h0, "R7 clear all", 32'(mask), 0);
    wr_port(4'd15, 8'hFA);
    chk(mask == 4'hA, "R7 load all", 32'(mask), 32'hA);
  endtask

  task automatic t_mode;
    wr_port(4'd11, 8'h46);
    wr_port(4'd11, 8'h48);
    wr_port(4'd11, 8'hC3);
    chk(mode[17:12] == 6'h11, "R8 ch2 mode", 32'(mode[17:12]), 32'h11);
    chk(mode[5:0] == 6'h12, "R8 ch0 mode", 32'(mode[5:0]), 32'h12);
    chk(mode[23:18] == 6'h30, "R8 ch3 mode", 32'(mode[23:18]), 32'h30);
    chk(mode[11:6] == 6'h00, "R8 ch1 untouched", 32'(mode[11:6]), 0);
  endtask

  task automatic t_cmd_req;
    logic [7:0] d;
    wr_port(4'd8, 8'h5A);
    chk(cmd == 8'h5A, "R9 command", 32'(cmd), 32'h5A);
    wr_port(4'd9, 8'h06);
    wr_port(4'd9, 8'h04);
    rd_port(4'd8, d);
    chk(d == 8'h50, "R9 status requests", 32'(d), 32'h50);
    wr_port(4'd9, 8'h00);
    chk(sw_req == 4'h4, "R9 clear req ch0", 32'(sw_req), 32'h4);
  endtask

  task automatic t_master_clear;
    wr_port(4'd12, 8'h00);
    wr_port(4'd4, 8'h99);   // pointer high
    wr_port(4'd13, 8'h00);
    chk(mask == 4'hF && cmd == 8'h00 && sw_req == 4'h0, "R10 master clear",
        {cmd, 4'h0, mask, 4'h0, sw_req}, 32'h000F00);
    chk(base_addr[31:16] == 16'h1234, "R10 regs kept", 32'(base_addr[31:16]), 32'h1234);
    wr_port(4'd4, 8'h22);
    chk(base_addr[47:32] == 16'h0022, "R10 pointer low", 32'(base_addr[47:32]), 32'h0022);
  endtask

  task automatic t_update;
    logic [7:0] lo, hi;
    @(negedge clk); upd_en = 4'b0010; upd_addr = 16'h2000; upd_cnt = 16'h0003;
    @(negedge clk); upd_en = '0;
    chk(cur_addr[31:16] == 16'h2000, "R11 cur addr update", 32'(cur_addr[31:16]), 32'h2000);
    chk(base_addr[31:16] == 16'h1234, "R11 base kept", 32'(base_addr[31:16]), 32'h1234);
    wr_port(4'd12, 8'h00);
    rd_port(4'd3, lo);
    rd_port(4'd3, hi);
    chk({hi, lo} == 16'h0003, "R4 current count read", 32'({hi, lo}), 32'h3);
    // host write wins over update on the same cycle
    @(negedge clk); upd_en = 4'b0010; upd_cnt = 16'hEEEE;
    addr = 4'd3; wdata = 8'h44; wr = 1'b1;
    @(negedge clk); upd_en = '0; wr = 1'b0;
    chk(cur_cnt[31:16] == base_cnt[31:16] && cur_cnt[23:16] == 8'h44, "R11 host priority",
        32'(cur_cnt[31:16]), 32'(base_cnt[31:16]));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_load();
    t_count_rw();
    t_shared_ptr();
    t_ptr_clear();
    t_single_mask();
    t_group_mask();
    t_mode();
    t_cmd_req();
    t_master_clear();
    t_update();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule